// File: doc/BRIEF.md
# Per-Port Transmit Credit Updater

This block keeps a transmit credit for every port of a multi-port packet link whose far end reports the fill state of its receive FIFOs. Credit is counted in 16-byte blocks. Each port owns an entry holding its credit, the last 2-bit FIFO status reported by the far end, and an update flag. The flag marks whether that status is new or has already been used.

The status capture logic writes a port's status field and sets its flag. When the transmit scheduler services a port, it presents the port index and the number of blocks it has just sent. The block reads the entry and looks at the flag first. A stale status is ignored. A new status is turned into a base credit using two programmable burst limits: the starving limit and the hungry limit. The burst is then subtracted from the base, with the result held at zero if the burst is larger.

The updated credit is written back and the flag is cleared, so each status report takes effect only once. One cycle later the block returns the new credit and a serve-allowed flag.

Top module: `tx_credit_updater`

## Requirements
- R1: After reset every port has credit 0, a clear update flag and status 11 (disabled), so the first service of any port returns serve 0 and credit 0.
- R2: A service request in cycle N gives `res_valid` = 1 in cycle N+1, with `res_port` equal to the requested port. With no request in cycle N, `res_valid` is 0 in cycle N+1.
- R3: When the port's update flag is clear, the stored status is ignored and the new credit is the old credit minus the burst.
- R4: When the flag is set and the status is 00 (starving), the new credit is `cfg_maxburst1` minus the burst.
- R5: When the flag is set and the status is 01 (hungry), the new credit is the larger of `cfg_maxburst2` and the old credit, minus the burst.
- R6: When the flag is set and the status is 10 (satisfied), no credit is granted and the new credit is the old credit minus the burst.
- R7: When the flag is set and the status is 11 (disabled), the credit becomes 0 and serve is 0.
- R8: Serve is 0 exactly when the base credit before subtraction is zero. In particular, a port with zero credit and a stale status is not served, and a result with serve 0 always carries credit 0.
- R9: Every subtraction of the burst holds at zero rather than wrapping.
- R10: A service clears the port's update flag, so a second service without a new status write behaves as R3. A status write stores the code and sets the flag. When a status write to the same port arrives in the same cycle as a service, the service uses the old entry, and the written status and a set flag remain afterwards.
- R11: A status write or a service to one port leaves every other port's entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_maxburst1 | input | CREDIT_W | Starving burst limit in blocks (not less than cfg_maxburst2) |
| cfg_maxburst2 | input | CREDIT_W | Hungry burst limit in blocks |
| stat_wr_en | input | 1 | Status capture write strobe |
| stat_wr_port | input | PORT_W | Port whose status is written |
| stat_wr_code | input | 2 | Status code: 00 starving, 01 hungry, 10 satisfied, 11 disabled |
| svc_req | input | 1 | Scheduler service request |
| svc_port | input | PORT_W | Port being serviced |
| svc_burst | input | CREDIT_W | Blocks just sent to that port |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_port | output | PORT_W | Port the result belongs to |
| res_credit | output | CREDIT_W | Credit written back for that port |
| res_serve | output | 1 | Port may be served |

## Verification
The bench targets the collision of a status write and a service on the same port. A design that gave priority to the flag clear would lose the fresh status, and one that forwarded the write would apply it one service too early. It also services the same port twice with no status write between. A design that kept the flag set would grant the same status a second time.

Bursts larger than the credit are driven to check the zero floor. A wrapping subtractor would return a huge credit together with serve 1. Hungry updates are run with the old credit both above and below the hungry limit, which catches a design that always loads the limit. Services of zero-credit stale ports must return serve 0.

// File: rtl/credit_pkg.sv
// Package: shared status encoding for the transmit credit updater.
// Assumes the far end reports one of four 2-bit fill levels per port.
package credit_pkg;
    typedef enum logic [1:0] {
        ST_STARVING  = 2'b00,
        ST_HUNGRY    = 2'b01,
        ST_SATISFIED = 2'b10,
        ST_DISABLED  = 2'b11
    } fifo_stat_e;
endpackage

// File: rtl/credit_entry_file.sv
// Module: credit_entry_file
// Holds one entry per port (credit, status code, update flag) in flops.
// Read of the serviced port is combinational. A service writes the credit and
// clears the flag; a status write in the same cycle to the same port wins for
// the status and flag fields.
// Assumes svc_port and stat_wr_port are below NUM_PORTS.
module credit_entry_file #(
    parameter int NUM_PORTS = 16,
    parameter int CREDIT_W  = 10,
    parameter int PORT_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stat_wr_en,
    input  logic [PORT_W-1:0]     stat_wr_port,
    input  logic [1:0]            stat_wr_code,
    input  logic                  svc_we,
    input  logic [PORT_W-1:0]     svc_port,
    input  logic [CREDIT_W-1:0]   svc_credit,
    output logic [CREDIT_W-1:0]   rd_credit,
    output logic [1:0]            rd_stat,
    output logic                  rd_flag,
    output logic [NUM_PORTS-1:0]  flag_vec
);
    logic [NUM_PORTS-1:0][CREDIT_W-1:0] credit_q;
    logic [NUM_PORTS-1:0][1:0]          stat_q;
    logic [NUM_PORTS-1:0]               flag_q;

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_entry
        logic hit_svc;
        logic hit_wr;
        assign hit_svc = svc_we && (svc_port == PORT_W'(gi));
        assign hit_wr  = stat_wr_en && (stat_wr_port == PORT_W'(gi));

        // Credit field: reloaded by a service of this port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                credit_q[gi] <= '0;
            else if (hit_svc)
                credit_q[gi] <= svc_credit;
        end

        // Status and flag: a status write sets, a service clears, the write wins.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q[gi] <= credit_pkg::ST_DISABLED;
                flag_q[gi] <= 1'b0;
            end else if (hit_wr) begin
                stat_q[gi] <= stat_wr_code;
                flag_q[gi] <= 1'b1;
            end else if (hit_svc) begin
                flag_q[gi] <= 1'b0;
            end
        end
    end

    // Combinational read of the entry being serviced.
    always_comb begin
        rd_credit = credit_q[svc_port];
        rd_stat   = stat_q[svc_port];
        rd_flag   = flag_q[svc_port];
    end

    assign flag_vec = flag_q;
endmodule

// File: rtl/credit_calc.sv
// Module: credit_calc
// Pure combinational credit computation for one service.
// A stale status keeps the old credit as base; a new status picks the base
// from the limits. The burst is then subtracted, held at zero.
// Assumes maxburst1 >= maxburst2, as required of the configuration.
module credit_calc #(
    parameter int CREDIT_W = 10
) (
    input  logic [CREDIT_W-1:0] old_credit,
    input  logic [1:0]          stat,
    input  logic                flag,
    input  logic [CREDIT_W-1:0] burst,
    input  logic [CREDIT_W-1:0] maxburst1,
    input  logic [CREDIT_W-1:0] maxburst2,
    output logic [CREDIT_W-1:0] new_credit,
    output logic                serve
);
    import credit_pkg::*;

    logic [CREDIT_W-1:0] base;

    // Base credit selection from the flag and the status level.
    always_comb begin
        base = old_credit;
        if (flag) begin
            case (fifo_stat_e'(stat))
                ST_STARVING:  base = maxburst1;
                ST_HUNGRY:    base = (maxburst2 > old_credit) ? maxburst2 : old_credit;
                ST_SATISFIED: base = old_credit;
                default:      base = '0;
            endcase
        end
    end

    // Serve decision and zero-floored subtraction of the burst.
    always_comb begin
        serve      = (base != '0);
        new_credit = (base > burst) ? (base - burst) : '0;
    end
endmodule

// File: rtl/credit_result_reg.sv
// Module: credit_result_reg
// One-cycle output register for the service result.
// Assumes the result is consumed in the cycle after the request.
module credit_result_reg #(
    parameter int CREDIT_W = 10,
    parameter int PORT_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [PORT_W-1:0]   in_port,
    input  logic [CREDIT_W-1:0] in_credit,
    input  logic                in_serve,
    output logic                out_valid,
    output logic [PORT_W-1:0]   out_port,
    output logic [CREDIT_W-1:0] out_credit,
    output logic                out_serve
);
    // Capture the result of this cycle's service; zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_port   <= '0;
            out_credit <= '0;
            out_serve  <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            out_port   <= in_valid ? in_port : '0;
            out_credit <= in_valid ? in_credit : '0;
            out_serve  <= in_valid && in_serve;
        end
    end
endmodule

// File: rtl/tx_credit_updater.sv
// Module: tx_credit_updater (top)
// Per-port transmit credit updater: one service per cycle, read-modify-write
// of the port entry in the same cycle, result registered one cycle later.
// Assumes cfg_maxburst1 >= cfg_maxburst2 and port indices below NUM_PORTS.
module tx_credit_updater #(
    parameter int NUM_PORTS = 16,
    parameter int CREDIT_W  = 10,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CREDIT_W-1:0] cfg_maxburst1,
    input  logic [CREDIT_W-1:0] cfg_maxburst2,
    input  logic                stat_wr_en,
    input  logic [PORT_W-1:0]   stat_wr_port,
    input  logic [1:0]          stat_wr_code,
    input  logic                svc_req,
    input  logic [PORT_W-1:0]   svc_port,
    input  logic [CREDIT_W-1:0] svc_burst,
    output logic                res_valid,
    output logic [PORT_W-1:0]   res_port,
    output logic [CREDIT_W-1:0] res_credit,
    output logic                res_serve
);
    logic [CREDIT_W-1:0]  rd_credit;
    logic [1:0]           rd_stat;
    logic                 rd_flag;
    logic [NUM_PORTS-1:0] flag_vec;
    logic [CREDIT_W-1:0]  calc_credit;
    logic                 calc_serve;

    credit_entry_file #(
        .NUM_PORTS(NUM_PORTS), .CREDIT_W(CREDIT_W), .PORT_W(PORT_W)
    ) u_file (
        .clk(clk), .rst_n(rst_n),
        .stat_wr_en(stat_wr_en), .stat_wr_port(stat_wr_port), .stat_wr_code(stat_wr_code),
        .svc_we(svc_req), .svc_port(svc_port), .svc_credit(calc_credit),
        .rd_credit(rd_credit), .rd_stat(rd_stat), .rd_flag(rd_flag),
        .flag_vec(flag_vec)
    );

    credit_calc #(.CREDIT_W(CREDIT_W)) u_calc (
        .old_credit(rd_credit), .stat(rd_stat), .flag(rd_flag), .burst(svc_burst),
        .maxburst1(cfg_maxburst1), .maxburst2(cfg_maxburst2),
        .new_credit(calc_credit), .serve(calc_serve)
    );

    credit_result_reg #(.CREDIT_W(CREDIT_W), .PORT_W(PORT_W)) u_res (
        .clk(clk), .rst_n(rst_n),
        .in_valid(svc_req), .in_port(svc_port), .in_credit(calc_credit), .in_serve(calc_serve),
        .out_valid(res_valid), .out_port(res_port), .out_credit(res_credit), .out_serve(res_serve)
    );
endmodule

// File: rtl/tx_credit_updater_chk.sv
// Module: tx_credit_updater_chk
// Assertion checker bound into tx_credit_updater; observes ports and the
// entry read and flag signals.
module tx_credit_updater_chk #(
    parameter int NUM_PORTS = 16,
    parameter int CREDIT_W  = 10,
    parameter int PORT_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CREDIT_W-1:0]  cfg_maxburst1,
    input logic                 stat_wr_en,
    input logic [PORT_W-1:0]    stat_wr_port,
    input logic                 svc_req,
    input logic [PORT_W-1:0]    svc_port,
    input logic [CREDIT_W-1:0]  svc_burst,
    input logic                 res_valid,
    input logic [PORT_W-1:0]    res_port,
    input logic [CREDIT_W-1:0]  res_credit,
    input logic                 res_serve,
    input logic [CREDIT_W-1:0]  rd_credit,
    input logic [1:0]           rd_stat,
    input logic                 rd_flag,
    input logic [NUM_PORTS-1:0] flag_vec
);
    p_result_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |=> (res_valid && res_port == $past(svc_port)));
    p_result_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !svc_req |=> !res_valid);
    p_stale_no_gain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && !rd_flag) |=> (res_credit <= $past(rd_credit)));
    p_starving_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && rd_flag && rd_stat == 2'b00 && svc_burst <= cfg_maxburst1)
        |=> (res_credit == $past(cfg_maxburst1 - svc_burst)));
    p_stale_zero_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && !rd_flag && rd_credit == '0) |=> !res_serve);
    p_no_serve_no_credit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_serve) |-> (res_credit == '0));
    p_write_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr_en |=> flag_vec[$past(stat_wr_port)]);
    p_service_clears_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && !(stat_wr_en && stat_wr_port == svc_port))
        |=> !flag_vec[$past(svc_port)]);
endmodule

bind tx_credit_updater tx_credit_updater_chk #(
    .NUM_PORTS(NUM_PORTS), .CREDIT_W(CREDIT_W), .PORT_W(PORT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_maxburst1(cfg_maxburst1),
    .stat_wr_en(stat_wr_en), .stat_wr_port(stat_wr_port),
    .svc_req(svc_req), .svc_port(svc_port), .svc_burst(svc_burst),
    .res_valid(res_valid), .res_port(res_port), .res_credit(res_credit), .res_serve(res_serve),
    .rd_credit(rd_credit), .rd_stat(rd_stat), .rd_flag(rd_flag), .flag_vec(flag_vec)
);

// File: tb/tx_credit_updater_tb_top.sv
// Bench for tx_credit_updater: directed corner cases then seeded random
// traffic, compared against a reference model kept in bench arrays.
module tx_credit_updater_tb_top;
    localparam int NP = 16;
    localparam int CW = 10;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_maxburst1 = 10'd64;
    logic [CW-1:0] cfg_maxburst2 = 10'd32;
    logic          stat_wr_en = 1'b0;
    logic [PW-1:0] stat_wr_port = '0;
    logic [1:0]    stat_wr_code = '0;
    logic          svc_req = 1'b0;
    logic [PW-1:0] svc_port = '0;
    logic [CW-1:0] svc_burst = '0;
    logic          res_valid;
    logic [PW-1:0] res_port;
    logic [CW-1:0] res_credit;
    logic          res_serve;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m_credit [NP];
    int m_stat   [NP];
    bit m_flag   [NP];

    always #5 clk = ~clk;

    tx_credit_updater #(.NUM_PORTS(NP), .CREDIT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_maxburst1(cfg_maxburst1), .cfg_maxburst2(cfg_maxburst2),
        .stat_wr_en(stat_wr_en), .stat_wr_port(stat_wr_port), .stat_wr_code(stat_wr_code),
        .svc_req(svc_req), .svc_port(svc_port), .svc_burst(svc_burst),
        .res_valid(res_valid), .res_port(res_port), .res_credit(res_credit), .res_serve(res_serve)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Base credit from the requirements R3..R7.
    function automatic int ref_base(input int old, input int st, input bit fl,
                                    input int mb1, input int mb2);
        if (!fl) return old;
        case (st)
            0: return mb1;
            1: return (mb2 > old) ? mb2 : old;
            2: return old;
            default: return 0;
        endcase
    endfunction

    function automatic string ref_tag(input int st, input bit fl);
        if (!fl) return "R3";
        case (st)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    // One cycle of stimulus, then a check of the registered result.
    task automatic step(input bit do_svc, input int port, input int burst,
                        input bit do_wr, input int wport, input int wcode, input string tag_in);
        int base;
        int exp_credit;
        bit exp_serve;
        string tag;
        @(negedge clk);
        svc_req = do_svc; svc_port = PW'(port); svc_burst = CW'(burst);
        stat_wr_en = do_wr; stat_wr_port = PW'(wport); stat_wr_code = 2'(wcode);
        exp_credit = 0; exp_serve = 0;
        tag = tag_in;
        if (do_svc) begin
            base = ref_base(m_credit[port], m_stat[port], m_flag[port],
                            int'(cfg_maxburst1), int'(cfg_maxburst2));
            if (tag == "") tag = ref_tag(m_stat[port], m_flag[port]);
            exp_serve = (base != 0);
            exp_credit = (base > burst) ? base - burst : 0;
            m_credit[port] = exp_credit;
            m_flag[port] = 1'b0;
        end
        if (do_wr) begin
            m_stat[wport] = wcode;
            m_flag[wport] = 1'b1;
        end
        @(posedge clk);
        #1;
        check("R2", "res_valid", int'(res_valid), int'(do_svc));
        if (do_svc) begin
            check("R2", "res_port", int'(res_port), port);
            check(tag, "res_credit", int'(res_credit), exp_credit);
            check(tag, "res_serve", int'(res_serve), int'(exp_serve));
        end
    endtask

    task automatic idle();
        step(1'b0, 0, 0, 1'b0, 0, 0, "R2");
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NP; i++) begin
            m_credit[i] = 0; m_stat[i] = 3; m_flag[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1;
        check("R1", "res_valid in reset", int'(res_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every port starts unserved with zero credit.
        for (int p = 0; p < NP; p++) step(1'b1, p, 5, 1'b0, 0, 0, "R1");
        idle();

        // R4 then R3: starving grant, then stale reuse.
        step(1'b0, 0, 0, 1'b1, 1, 0, "R4");
        step(1'b1, 1, 3, 1'b0, 0, 0, "R4");
        step(1'b1, 1, 2, 1'b0, 0, 0, "R3");
        // R5 with old credit above the hungry limit (59 > 32).
        step(1'b0, 0, 0, 1'b1, 1, 1, "R5");
        step(1'b1, 1, 4, 1'b0, 0, 0, "R5");
        // R9: burst beyond credit floors at zero.
        step(1'b1, 1, 900, 1'b0, 0, 0, "R9");
        // R8: zero credit and stale status gives no service.
        step(1'b1, 1, 0, 1'b0, 0, 0, "R8");
        // R5 with old credit below the hungry limit.
        step(1'b0, 0, 0, 1'b1, 1, 1, "R5");
        step(1'b1, 1, 10, 1'b0, 0, 0, "R5");
        // R6: satisfied grants nothing new.
        step(1'b0, 0, 0, 1'b1, 1, 2, "R6");
        step(1'b1, 1, 7, 1'b0, 0, 0, "R6");
        // R7: disabled zeroes the credit.
        step(1'b0, 0, 0, 1'b1, 1, 3, "R7");
        step(1'b1, 1, 0, 1'b0, 0, 0, "R7");
        // R10: same-port write during service; service sees old entry.
        step(1'b0, 0, 0, 1'b1, 4, 2, "R10");
        step(1'b1, 4, 1, 1'b1, 4, 0, "R10");
        step(1'b1, 4, 6, 1'b0, 0, 0, "R10");
        step(1'b1, 4, 6, 1'b0, 0, 0, "R10");
        // R11: write to port 2 while servicing port 3.
        step(1'b1, 3, 0, 1'b1, 2, 0, "R11");
        step(1'b1, 3, 0, 1'b0, 0, 0, "R11");
        step(1'b1, 2, 1, 1'b0, 0, 0, "R11");
        idle();

        // Seeded random traffic with occasional limit changes.
        for (int n = 0; n < 3000; n++) begin
            bit dsv;
            bit dwr;
            if (n % 500 == 250) begin
                @(negedge clk);
                seed = 16 + int'($urandom_range(0, 300));
                cfg_maxburst1 = CW'(seed);
                cfg_maxburst2 = CW'($urandom_range(0, seed));
            end
            dsv = ($urandom_range(0, 9) < 7);
            dwr = ($urandom_range(0, 1) == 1);
            step(dsv, int'($urandom_range(0, NP-1)), int'($urandom_range(0, 80)),
                 dwr, int'($urandom_range(0, NP-1)), int'($urandom_range(0, 3)), "");
        end
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule